// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host controller to an AT/PS/2 keyboard. Both wires of the link are open-drain, so the block only ever pulls them low: it drives a pull-low enable for each line and reads the resolved line levels back through two-flop synchronizers. The keyboard generates every clock pulse, even when the host is the sender. To start a transfer, the host first inhibits the link by holding the clock low. It then pulls data low as the start bit and releases the clock. From that point it follows the keyboard's falling clock edges.

After each falling edge seen on the synchronized clock, the host presents the next bit: the eight data bits least significant first, then an odd parity bit, then a released line as the stop bit. On the eleventh falling edge the block samples the data line to read the keyboard's acknowledge. The result is reported as a one-cycle done pulse or a one-cycle error pulse. There are two error causes: a missing acknowledge, or a timeout. A timeout is raised when the first clock edge never arrives, or when the whole frame takes too long.

The byte enters on a valid/ready port. `tx_ready` is high only while the block is idle. A byte is taken in any cycle where `tx_valid` and `tx_ready` are both high, and `tx_data` is captured in that cycle. While a transfer is in flight `tx_ready` stays low and the block ignores `tx_valid`, so the upstream side holds its byte until the block returns to idle. Every time constant is given in microseconds and converted to cycles from `CLK_FREQ_HZ`, which must be a whole multiple of 1 MHz.

Top module: `ps2h_tx`

## Requirements
- R1: `tx_ready` is high exactly when the block is idle. A byte is accepted on a clock edge with `tx_valid` and `tx_ready` both high. While busy, `tx_valid` and `tx_data` have no effect on the frame in flight.
- R2: In the cycle after acceptance, `ps2_clk_pull` is 1 and `ps2_dat_pull` is 0. The clock stays pulled for at least `INHIBIT_US` microseconds.
- R3: `ps2_dat_pull` becomes 1 while `ps2_clk_pull` is still 1. When the clock is released, data remains pulled, and the keyboard reads this as the start bit, a 0.
- R4: After falling line-clock edges 1 to 8, the data line carries data bits 0 to 7 in that order (least significant first). A pull of 1 means a 0 on the line.
- R5: After falling edge 9, the data line carries an odd parity bit. This bit is 1 when the data byte has an even number of ones.
- R6: After falling edge 10, `ps2_dat_pull` is 0, so the line reads 1 as the stop bit.
- R7: On falling edge 11, a low data line produces a one-cycle `done` pulse, and a high data line produces a one-cycle `err_noack` pulse. At most one of `done`, `err_noack` and `err_timeout` is high in any cycle.
- R8: If no falling clock edge arrives within `FIRST_CLK_US` microseconds after the clock is released, `err_timeout` pulses and the block returns to idle.
- R9: If the eleventh edge has not arrived within `XFER_US` microseconds after the first falling edge, `err_timeout` pulses and the block returns to idle.
- R10: In every idle cycle, including the cycle of any outcome pulse, both pull enables are 0.
- R11: `busy` is the inverse of `tx_ready`. `busy` falls only in a cycle that carries an outcome pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Command byte offered |
| tx_data | input | 8 | Command byte |
| tx_ready | output | 1 | Block idle, byte will be taken |
| ps2_clk_i | input | 1 | Resolved clock line level |
| ps2_dat_i | input | 1 | Resolved data line level |
| ps2_clk_pull | output | 1 | 1 pulls the clock line low |
| ps2_dat_pull | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: acknowledge received |
| err_noack | output | 1 | One-cycle pulse: acknowledge missing |
| err_timeout | output | 1 | One-cycle pulse: clock absent or frame too slow |

## Verification
A wrong bit count or a shift register that lost its place shows up at the keyboard model within one line-clock period. The bits it collects are shifted, the parity is wrong, or the stop bit reads 0, and any of these is caught before the acknowledge edge. A stuck or mis-loaded timer shows up either as an inhibit phase shorter than the limit, measured from the first released cycle, or as a timeout pulse that arrives too early or never. An FSM that fails to release the lines is visible at the pins in the same cycle as the outcome pulse.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int unsigned BYTE_W = 8;
  // Falling edges counted after the start bit: 8 data, parity, stop, acknowledge.
  localparam int unsigned ACK_EDGE = BYTE_W + 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_REQ,
    ST_WAIT,
    ST_SHIFT
  } ps2h_state_e;

  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2h_timer.sv
module ps2h_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
  import ps2h_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ  = 100_000_000,
  parameter int unsigned INHIBIT_US   = 100,
  parameter int unsigned FIRST_CLK_US = 20_000,
  parameter int unsigned XFER_US      = 2_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_pull,
  output logic              ps2_dat_pull,
  output logic              busy,
  output logic              done,
  output logic              err_noack,
  output logic              err_timeout
);
  localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned INH_CYC    = CYC_PER_US * INHIBIT_US;
  localparam int unsigned FIRST_CYC  = CYC_PER_US * FIRST_CLK_US;
  localparam int unsigned XFER_CYC   = CYC_PER_US * XFER_US;
  localparam int unsigned MAX_A      = (INH_CYC > FIRST_CYC) ? INH_CYC : FIRST_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > XFER_CYC) ? MAX_A : XFER_CYC;
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);
  localparam int unsigned SH_W       = BYTE_W + 2;
  localparam int unsigned EW         = $clog2(ACK_EDGE + 1);

  ps2h_state_e state;
  logic [SH_W-1:0] shreg;
  logic [EW-1:0]   ecnt;
  logic            clk_pull_q, dat_pull_q;
  logic            done_q, noack_q, tmo_q;

  // Line synchronizers and falling-edge detection
  logic [1:0] line_s;
  logic       clk_prev, clk_fall, dat_s;

  ps2h_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ps2_dat_i, ps2_clk_i}),
    .q    (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= line_s[0];
  end

  assign clk_fall = clk_prev & ~line_s[0];
  assign dat_s    = line_s[1];

  // Shared countdown for the inhibit, first-edge and frame windows
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:  if (tx_valid) begin tmr_load = 1'b1; tmr_val = TW'(INH_CYC); end
      ST_REQ:   begin tmr_load = 1'b1; tmr_val = TW'(FIRST_CYC); end
      ST_WAIT:  if (clk_fall) begin tmr_load = 1'b1; tmr_val = TW'(XFER_CYC); end
      default:  ;
    endcase
  end

  ps2h_timer #(.W(TW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  // Transfer sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      ecnt       <= '0;
      clk_pull_q <= 1'b0;
      dat_pull_q <= 1'b0;
      done_q     <= 1'b0;
      noack_q    <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      noack_q <= 1'b0;
      tmo_q   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          clk_pull_q <= 1'b0;
          dat_pull_q <= 1'b0;
          if (tx_valid) begin
            shreg      <= {1'b1, odd_par(tx_data), tx_data};
            ecnt       <= '0;
            clk_pull_q <= 1'b1;
            state      <= ST_INHIBIT;
          end
        end
        ST_INHIBIT: begin
          if (tmr_zero) begin
            dat_pull_q <= 1'b1;
            state      <= ST_REQ;
          end
        end
        ST_REQ: begin
          clk_pull_q <= 1'b0;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (clk_fall) begin
            dat_pull_q <= ~shreg[0];
            shreg      <= {1'b1, shreg[SH_W-1:1]};
            ecnt       <= EW'(1);
            state      <= ST_SHIFT;
          end else if (tmr_zero) begin
            dat_pull_q <= 1'b0;
            tmo_q      <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (clk_fall) begin
            if (ecnt == EW'(ACK_EDGE - 1)) begin
              done_q     <= ~dat_s;
              noack_q    <= dat_s;
              dat_pull_q <= 1'b0;
              state      <= ST_IDLE;
            end else begin
              dat_pull_q <= ~shreg[0];
              shreg      <= {1'b1, shreg[SH_W-1:1]};
              ecnt       <= ecnt + 1'b1;
            end
          end else if (tmr_zero) begin
            dat_pull_q <= 1'b0;
            tmo_q      <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready     = (state == ST_IDLE);
  assign busy         = (state != ST_IDLE);
  assign ps2_clk_pull = clk_pull_q;
  assign ps2_dat_pull = dat_pull_q;
  assign done         = done_q;
  assign err_noack    = noack_q;
  assign err_timeout  = tmo_q;
endmodule

// File: rtl/ps2h_tx_chk.sv
module ps2h_tx_chk #(
  parameter int unsigned INH_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic ps2_clk_pull,
  input logic ps2_dat_pull,
  input logic busy,
  input logic done,
  input logic err_noack,
  input logic err_timeout
);
  logic [31:0] inh_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            inh_run <= '0;
    else if (ps2_clk_pull) inh_run <= inh_run + 1;
    else                   inh_run <= '0;
  end

  assert_accept_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (ps2_clk_pull && !ps2_dat_pull && busy));

  assert_inhibit_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull) |-> (inh_run >= INH_CYC));

  assert_start_before_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull) |-> ps2_dat_pull);

  assert_single_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_noack, err_timeout}));

  assert_released_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!ps2_clk_pull && !ps2_dat_pull));

  assert_outcome_in_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_noack || err_timeout) |-> tx_ready);

  assert_busy_ends_with_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err_noack || err_timeout));
endmodule

bind ps2h_tx ps2h_tx_chk #(.INH_CYC(INH_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .ps2_clk_pull(ps2_clk_pull),
  .ps2_dat_pull(ps2_dat_pull),
  .busy        (busy),
  .done        (done),
  .err_noack   (err_noack),
  .err_timeout (err_timeout)
);

// File: tb/tb_ps2h_tx.sv
module tb_ps2h_tx;
  localparam int INH_US   = 100;
  localparam int FIRST_US = 20000;
  localparam int XFER_US  = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, ps2_clk_pull, ps2_dat_pull, busy, done, err_noack, err_timeout;
  logic       kb_clk_low = 1'b0, kb_dat_low = 1'b0;
  logic       line_clk, line_dat;

  int n_checks = 0, n_fail = 0;
  int n_done = 0, n_noack = 0, n_tmo = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign line_clk = !(ps2_clk_pull || kb_clk_low);
  assign line_dat = !(ps2_dat_pull || kb_dat_low);

  ps2h_tx #(
    .CLK_FREQ_HZ (1_000_000),
    .INHIBIT_US  (INH_US),
    .FIRST_CLK_US(FIRST_US),
    .XFER_US     (XFER_US)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ps2_clk_i(line_clk), .ps2_dat_i(line_dat), .ps2_clk_pull(ps2_clk_pull),
    .ps2_dat_pull(ps2_dat_pull), .busy(busy), .done(done), .err_noack(err_noack),
    .err_timeout(err_timeout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && done)        n_done  <= n_done + 1;
    if (rst_n && err_noack)   n_noack <= n_noack + 1;
    if (rst_n && err_timeout) n_tmo   <= n_tmo + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit par_of(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(b[i]);
    return (ones % 2 == 0);
  endfunction

  // Hand a byte over and measure the inhibit phase (R1, R2, R3)
  task automatic host_send(input logic [7:0] b);
    int run = 0;
    bit dat_early = 0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1 ready before send", int'(tx_ready), 1);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0; tx_data = 8'h00;
    check(ps2_clk_pull && !ps2_dat_pull && busy, "R2 inhibit starts",
          int'({ps2_clk_pull, ps2_dat_pull, busy}), 5);
    check(!tx_ready, "R11 ready low while busy", int'(tx_ready), 0);
    while (ps2_clk_pull && run < 5000) begin
      if (ps2_dat_pull) dat_early = 1;
      run++;
      @(negedge clk);
    end
    check(run >= INH_US, "R2 inhibit length", run, INH_US);
    check(dat_early && ps2_dat_pull, "R3 data low before clock release",
          int'({dat_early, ps2_dat_pull}), 3);
  endtask

  // Keyboard model: generates clock, collects the frame, optionally acknowledges
  task automatic kb_frame(input int half, input bit ack, output logic [10:0] bits, output bit aborted);
    int guard = 0;
    aborted = 0;
    bits = '1;
    while (!(line_clk && !line_dat) && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    bits[0] = line_dat;
    repeat (20) @(negedge clk);
    for (int i = 1; i <= 10; i++) begin
      kb_clk_low = 1'b1;
      repeat (half) @(negedge clk);
      kb_clk_low = 1'b0;
      bits[i] = line_dat;
      repeat (half) @(negedge clk);
      if (!busy) begin aborted = 1; break; end
    end
    if (!aborted) begin
      if (ack) kb_dat_low = 1'b1;
      repeat (half / 2) @(negedge clk);
      kb_clk_low = 1'b1;
      repeat (half) @(negedge clk);
      kb_clk_low = 1'b0;
      repeat (4) @(negedge clk);
      kb_dat_low = 1'b0;
    end
    kb_clk_low = 1'b0;
    kb_dat_low = 1'b0;
  endtask

  task automatic check_frame(input logic [10:0] bits, input logic [7:0] b, input string tag);
    check(bits[0] == 1'b0, {"R3 start bit ", tag}, int'(bits[0]), 0);
    check(bits[8:1] == b, {"R4 data bits ", tag}, int'(bits[8:1]), int'(b));
    check(bits[9] == par_of(b), {"R5 parity ", tag}, int'(bits[9]), int'(par_of(b)));
    check(bits[10] == 1'b1, {"R6 stop bit ", tag}, int'(bits[10]), 1);
  endtask

  task automatic wait_idle(input int limit);
    int k = 0;
    while (busy && k < limit) begin k++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(tx_ready && !busy, "R11 reset idle", int'({tx_ready, busy}), 2);
    check(!ps2_clk_pull && !ps2_dat_pull, "R10 reset lines released",
          int'({ps2_clk_pull, ps2_dat_pull}), 0);
    check(!done && !err_noack && !err_timeout, "R7 reset flags",
          int'({done, err_noack, err_timeout}), 0);
  endtask

  task automatic t_good(input logic [7:0] b);
    logic [10:0] bits;
    bit ab;
    int d0 = n_done, e0 = n_noack + n_tmo;
    host_send(b);
    kb_frame(40, 1'b1, bits, ab);
    wait_idle(50);
    check_frame(bits, b, "ack");
    check(n_done == d0 + 1 && n_noack + n_tmo == e0, "R7 done pulse",
          n_done - d0, 1);
    check(tx_ready && !ps2_clk_pull && !ps2_dat_pull, "R10 released after done",
          int'({tx_ready, ps2_clk_pull, ps2_dat_pull}), 4);
  endtask

  task automatic t_noack;
    logic [10:0] bits;
    bit ab;
    int e0 = n_noack, d0 = n_done;
    host_send(8'hED);
    kb_frame(40, 1'b0, bits, ab);
    wait_idle(50);
    check_frame(bits, 8'hED, "noack");
    check(n_noack == e0 + 1 && n_done == d0, "R7 missing acknowledge", n_noack - e0, 1);
    check(!ps2_clk_pull && !ps2_dat_pull, "R10 released after noack",
          int'({ps2_clk_pull, ps2_dat_pull}), 0);
  endtask

  task automatic t_first_timeout;
    int t0, el, e0 = n_tmo;
    host_send(8'hF4);
    t0 = cycles;
    wait_idle(FIRST_US + 500);
    el = cycles - t0;
    check(n_tmo == e0 + 1, "R8 first-edge timeout pulse", n_tmo - e0, 1);
    check(el >= FIRST_US && el <= FIRST_US + 50, "R8 first-edge timeout delay", el, FIRST_US);
    check(!ps2_clk_pull && !ps2_dat_pull && tx_ready, "R10 released after timeout",
          int'({ps2_clk_pull, ps2_dat_pull, tx_ready}), 1);
  endtask

  task automatic t_slow_timeout;
    logic [10:0] bits;
    bit ab;
    int e0 = n_tmo, d0 = n_done;
    host_send(8'h55);
    kb_frame(150, 1'b1, bits, ab);
    wait_idle(50);
    check(ab == 1'b1, "R9 frame cut short", int'(ab), 1);
    check(n_tmo == e0 + 1 && n_done == d0, "R9 frame timeout pulse", n_tmo - e0, 1);
  endtask

  task automatic t_ignore_busy;
    logic [10:0] bits;
    bit ab;
    int d0 = n_done;
    host_send(8'hA5);
    fork
      kb_frame(40, 1'b1, bits, ab);
      begin
        repeat (200) @(negedge clk);
        tx_valid = 1'b1; tx_data = 8'h3C;
        @(negedge clk);
        check(!tx_ready, "R1 ready low during transfer", int'(tx_ready), 0);
        repeat (4) @(negedge clk);
        tx_valid = 1'b0; tx_data = 8'h00;
      end
    join
    wait_idle(50);
    check_frame(bits, 8'hA5, "busy-poke");
    check(n_done == d0 + 1, "R1 poke did not disturb outcome", n_done - d0, 1);
    repeat (3) @(negedge clk);
    check(tx_ready && !busy && !ps2_clk_pull, "R1 poke not queued",
          int'({tx_ready, busy, ps2_clk_pull}), 4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_good(8'hA5);
    t_good(8'h00);
    t_good(8'hFF);
    t_good(8'h01);
    t_noack();
    t_first_timeout();
    t_slow_timeout();
    t_ignore_busy();
    t_good(8'h80);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule